// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This block sits between the interrupt status logic and the processor's normal interrupt input. It holds sixteen vector slots, each a 6-bit control word and a 32-bit handler address. A slot watches one line of the 32-bit normal status vector. Its request is ranked against the other slots, against a nonvectored request, and against a request arriving from a daisy-chained controller. The winner drives an active-low interrupt line and selects the handler address presented on the vector output.

Software reads the vector address through a one-cycle read strobe. The read returns the winning address and records the winner's level as in service, which blocks that level and every lower level. A one-cycle write strobe acknowledges completion and restores the level that was in service before. Nesting is tracked per level, so a higher-priority request can interrupt a handler that is already running. There is no data stream in this block. Configuration, strobes and requests are plain level or pulse pins sampled on the rising clock edge, and nothing is held off by back-pressure.

Top module: `vic_prio_unit`

## Requirements
- R1: Among active slot requests, the lowest-numbered slot wins: slot 0 has the highest priority and slot 15 the lowest.
- R2: A slot requests only when bit 5 of its control word is 1 and the status line selected by bits 4:0 of that word is 1. A slot whose bit 5 is 0 never requests.
- R3: When `cfg_we` is high at a clock edge, the slot named by `cfg_slot` takes `cfg_ctrl` and `cfg_addr`, and the new values take effect from the next cycle. When `dflt_we` is high at a clock edge, the default address takes `dflt_wdata`. After reset every control word, slot address and the default address is 0.
- R4: The nonvectored request is level 16. It ranks below all slots and presents the default address.
- R5: The daisy-chain request (`chain_req_n`, active low) is level 17. It ranks below the nonvectored request and presents `chain_addr`. With no request at all, `irq_n` stays high.
- R6: `irq_n` is low exactly when the highest-priority pending level has a smaller number than the current in-service level. When nothing is in service, any pending level qualifies.
- R7: A read (`vec_rd`) while `irq_n` is low returns the winner's address on `vec_addr` in that cycle. The winner's level then becomes the current in-service level from the next cycle, which masks that level and all lower levels.
- R8: A write (`vec_ack`) while some level is in service removes the most recently entered level, so the previous level, or none, becomes current in the next cycle.
- R9: While `irq_n` is high, `vec_addr` shows the address of the current in-service level, or the default address if nothing is in service. A read in that state changes no state.
- R10: When `vec_rd` and `vec_ack` are both high in one cycle, only the acknowledge takes effect.
- R11: After reset nothing is in service, every slot is disabled, `irq_n` is high and `vec_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the slot configuration |
| cfg_slot | input | 4 | Slot index for a configuration write |
| cfg_ctrl | input | 6 | Control word: bit 5 enable, bits 4:0 source line |
| cfg_addr | input | 32 | Handler address for the slot |
| dflt_we | input | 1 | Write strobe for the default address |
| dflt_wdata | input | 32 | New default (nonvectored) address |
| irq_status | input | 32 | Normal status vector, one bit per source |
| nonvect_req | input | 1 | Combined nonvectored normal request |
| chain_req_n | input | 1 | Daisy-chain request, active low |
| chain_addr | input | 32 | Address supplied by the daisy-chained controller |
| vec_rd | input | 1 | Vector address read strobe |
| vec_ack | input | 1 | Vector address write (acknowledge) strobe |
| vec_addr | output | 32 | Vector address presented to software |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The embedded properties assume that every input is synchronous to `clk`, known after reset, and that each strobe stands for one access per cycle in which it is high. They also assume that a read is meaningful in every cycle, including cycles with nothing pending. The stimulus follows this by driving all inputs only at the falling edge, never leaving a bit unknown after reset, and mixing directed nesting sequences with random pulses. These pulses include reads with nothing pending, acknowledges with nothing in service, and cycles where read and acknowledge coincide.

// File: rtl/vic_prio_pkg.sv
package vic_prio_pkg;

  typedef enum logic [1:0] {
    LK_SLOT    = 2'd0,
    LK_DEFAULT = 2'd1,
    LK_CHAIN   = 2'd2,
    LK_NONE    = 2'd3
  } lvl_kind_e;

  // Levels 0..nslots-1 are slots, nslots is nonvectored, nslots+1 daisy chain,
  // anything above is the idle marker.
  function automatic lvl_kind_e classify_lvl(input int lvl, input int nslots);
    if (lvl < nslots)           return LK_SLOT;
    else if (lvl == nslots)     return LK_DEFAULT;
    else if (lvl == nslots + 1) return LK_CHAIN;
    else                        return LK_NONE;
  endfunction

endpackage

// File: rtl/vic_slot_bank.sv
module vic_slot_bank #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int ADDR_W    = 32,
  localparam int SEL_W    = $clog2(SRC_W),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [SLOT_W-1:0]                 cfg_slot,
  input  logic [SEL_W:0]                    cfg_ctrl,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [SRC_W-1:0]                  status,
  output logic [NUM_SLOTS-1:0]              slot_req,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [SEL_W:0]    ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        addr_q <= '0;
      end else if (cfg_we && cfg_slot == SLOT_W'(g)) begin
        ctrl_q <= cfg_ctrl;
        addr_q <= cfg_addr;
      end
    end

    assign hit          = status[ctrl_q[SEL_W-1:0]];
    assign slot_req[g]  = ctrl_q[SEL_W] & hit;
    assign slot_addr[g] = addr_q;

    // R2: writing a cleared enable bit silences the slot from the next cycle
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_slot == SLOT_W'(g) && !cfg_ctrl[SEL_W]) |=> !slot_req[g]);
  end

endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NUM_SLOTS   = 16,
  localparam int NUM_LEVELS = NUM_SLOTS + 2,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  logic                 nonvect_req,
  input  logic                 chain_req,
  output logic                 win_valid,
  output logic [LVL_W-1:0]     win_lvl
);

  logic [NUM_LEVELS-1:0] req_all;
  logic [NUM_LEVELS-1:0] grant;

  assign req_all = {chain_req, nonvect_req, slot_req};
  // isolate lowest set bit, used only to cross-check the encoder
  assign grant   = req_all & ~(req_all - NUM_LEVELS'(1));

  always_comb begin
    win_lvl = LVL_W'(NUM_LEVELS);
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (req_all[i]) win_lvl = LVL_W'(i);
    end
  end

  assign win_valid = |req_all;

  // R1: exactly one level wins and it is the encoder's choice
  p_single_winner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (win_valid == (grant != '0)));
  p_winner_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> grant[win_lvl]);

endmodule

// File: rtl/vic_service_track.sv
module vic_service_track #(
  parameter int NUM_LEVELS = 18,
  localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop_en,
  output logic [LVL_W-1:0] cur_lvl,
  output logic             busy
);

  // Pushed levels strictly rise in priority, so a set of levels ordered by
  // number behaves exactly like a stack whose top is the lowest set bit.
  logic [NUM_LEVELS-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (pop_en)       mask_d = mask_q & (mask_q - NUM_LEVELS'(1));
    else if (push_en) mask_d[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_comb begin
    cur_lvl = LVL_W'(NUM_LEVELS);
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (mask_q[i]) cur_lvl = LVL_W'(i);
    end
  end

  assign busy = |mask_q;

  // R7: a push only ever enters a level above the current one, which then leads
  p_push_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (push_lvl < cur_lvl));
  p_push_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en) |=> (cur_lvl == $past(push_lvl)));
  // R8: an acknowledge removes exactly one level
  p_pop_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && busy) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

endmodule

// File: rtl/vic_prio_unit.sv
module vic_prio_unit #(
  parameter int NUM_SLOTS   = 16,
  parameter int SRC_W       = 32,
  parameter int ADDR_W      = 32,
  localparam int SEL_W      = $clog2(SRC_W),
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int NUM_LEVELS = NUM_SLOTS + 2,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SEL_W:0]    cfg_ctrl,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              dflt_we,
  input  logic [ADDR_W-1:0] dflt_wdata,
  input  logic [SRC_W-1:0]  irq_status,
  input  logic              nonvect_req,
  input  logic              chain_req_n,
  input  logic [ADDR_W-1:0] chain_addr,
  input  logic              vec_rd,
  input  logic              vec_ack,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              irq_n
);
  import vic_prio_pkg::*;

  logic [NUM_SLOTS-1:0]             slot_req;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [ADDR_W-1:0]                dflt_q;
  logic                             win_valid;
  logic [LVL_W-1:0]                 win_lvl;
  logic [LVL_W-1:0]                 cur_lvl;
  logic                             busy;
  logic                             eligible;
  logic                             push_en;
  logic                             pop_en;

  function automatic logic [ADDR_W-1:0] level_addr(
    input logic [LVL_W-1:0]                 lvl,
    input logic [NUM_SLOTS-1:0][ADDR_W-1:0] sa,
    input logic [ADDR_W-1:0]                dflt,
    input logic [ADDR_W-1:0]                chain
  );
    case (classify_lvl(int'(lvl), NUM_SLOTS))
      LK_SLOT:  return sa[lvl[SLOT_W-1:0]];
      LK_CHAIN: return chain;
      default:  return dflt;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dflt_q <= '0;
    else if (dflt_we) dflt_q <= dflt_wdata;
  end

  vic_slot_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .SRC_W     (SRC_W),
    .ADDR_W    (ADDR_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_slot  (cfg_slot),
    .cfg_ctrl  (cfg_ctrl),
    .cfg_addr  (cfg_addr),
    .status    (irq_status),
    .slot_req  (slot_req),
    .slot_addr (slot_addr)
  );

  vic_prio_pick #(
    .NUM_SLOTS   (NUM_SLOTS)
  ) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_req    (slot_req),
    .nonvect_req (nonvect_req),
    .chain_req   (~chain_req_n),
    .win_valid   (win_valid),
    .win_lvl     (win_lvl)
  );

  assign eligible = win_valid && (win_lvl < cur_lvl);
  assign pop_en   = vec_ack && busy;
  assign push_en  = vec_rd && !vec_ack && eligible;

  vic_service_track #(
    .NUM_LEVELS (NUM_LEVELS)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (push_en),
    .push_lvl (win_lvl),
    .pop_en   (pop_en),
    .cur_lvl  (cur_lvl),
    .busy     (busy)
  );

  assign irq_n    = !eligible;
  assign vec_addr = eligible ? level_addr(win_lvl, slot_addr, dflt_q, chain_addr)
                             : level_addr(cur_lvl, slot_addr, dflt_q, chain_addr);

  // R5: with no request from any source the line stays inactive
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nonvect_req && chain_req_n && slot_req == '0) |-> irq_n);
  // R9: a read with nothing eligible leaves the in-service level alone
  p_quiet_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !vec_ack && irq_n) |=> $stable(cur_lvl));
  // R10: read and acknowledge together never raise the in-service priority
  p_ack_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_ack) |=> (cur_lvl >= $past(cur_lvl)));

endmodule

// File: tb/vic_prio_unit_tb.sv
module vic_prio_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_slot = '0;
  logic [5:0]  cfg_ctrl = '0;
  logic [31:0] cfg_addr = '0;
  logic        dflt_we = 1'b0;
  logic [31:0] dflt_wdata = '0;
  logic [31:0] irq_status = '0;
  logic        nonvect_req = 1'b0;
  logic        chain_req_n = 1'b1;
  logic [31:0] chain_addr = '0;
  logic        vec_rd = 1'b0;
  logic        vec_ack = 1'b0;
  logic [31:0] vec_addr;
  logic        irq_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R11";

  logic [5:0]  m_ctrl [16];
  logic [31:0] m_addr [16];
  logic [31:0] m_dflt;
  int          m_stk [$];

  always #10 clk = ~clk;

  vic_prio_unit u_dut (
    .clk, .rst_n, .cfg_we, .cfg_slot, .cfg_ctrl, .cfg_addr, .dflt_we, .dflt_wdata,
    .irq_status, .nonvect_req, .chain_req_n, .chain_addr, .vec_rd, .vec_ack,
    .vec_addr, .irq_n
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired: act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] m_lvl_addr(int l);
    if (l < 16) return m_addr[l];
    if (l == 17) return chain_addr;
    return m_dflt;
  endfunction

  function automatic int m_winner();
    for (int s = 0; s < 16; s++)
      if (m_ctrl[s][5] && irq_status[m_ctrl[s][4:0]]) return s;
    if (nonvect_req) return 16;
    if (!chain_req_n) return 17;
    return 18;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // compare model to outputs before the coming edge, then advance the model
  task automatic tick();
    int win, cur;
    logic elig;
    #2;
    win  = m_winner();
    cur  = (m_stk.size() == 0) ? 18 : m_stk[$];
    elig = (win < cur);
    check("irq_n", {31'd0, irq_n}, {31'd0, !elig});
    check("vec_addr", vec_addr, elig ? m_lvl_addr(win) : m_lvl_addr(cur));
    if (cfg_we) begin
      m_ctrl[cfg_slot] = cfg_ctrl;
      m_addr[cfg_slot] = cfg_addr;
    end
    if (dflt_we) m_dflt = dflt_wdata;
    if (vec_ack) begin
      if (m_stk.size() != 0) void'(m_stk.pop_back());
    end else if (vec_rd && elig) begin
      m_stk.push_back(win);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    cfg_we = 0; dflt_we = 0; vec_rd = 0; vec_ack = 0;
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_ctrl[s] = '0;
      m_addr[s] = '0;
    end
    m_dflt = '0;

    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("reset irq_n", {31'd0, irq_n}, 32'd1);
    check("reset vec_addr", vec_addr, 32'd0);
    rst_n = 1'b1;
    tick();

    // R3: program every slot to watch its own index, and the default address
    tag = "R3";
    for (int s = 0; s < 16; s++) begin
      cfg_we = 1; cfg_slot = 4'(s); cfg_ctrl = {1'b1, 5'(s)};
      cfg_addr = 32'h1000 + 32'(s) * 32'h10;
      tick();
    end
    cfg_we = 0; dflt_we = 1; dflt_wdata = 32'hDEF0;
    tick();
    dflt_we = 0;
    irq_status = 32'h0000_0200;
    tick();

    // R2: source line outside all selections, then a disabled slot
    tag = "R2";
    irq_status = 32'h0010_0000;
    tick();
    irq_status = 0; cfg_we = 1; cfg_slot = 4'd5; cfg_ctrl = 6'h05; cfg_addr = 32'h1050;
    tick();
    cfg_we = 0; irq_status = 32'h0000_0020;
    tick();

    // R1: two slots compete
    tag = "R1";
    irq_status = 32'h0000_1008;
    tick();
    irq_status = 32'h0000_C000;
    tick();

    // R4: nonvectored request, alone and below a slot
    tag = "R4";
    irq_status = 0; nonvect_req = 1;
    tick();
    irq_status = 32'h0000_0010;
    tick();

    // R5: daisy chain, alone and below nonvectored
    tag = "R5";
    irq_status = 0; nonvect_req = 0; chain_req_n = 0; chain_addr = 32'hC0C0;
    tick();
    nonvect_req = 1;
    tick();
    nonvect_req = 0; chain_req_n = 1;
    tick();

    // R7: read enters slot 8, lower request 10 then masked, slot 2 nests
    tag = "R7";
    irq_status = 32'h0000_0100; vec_rd = 1;
    tick();
    vec_rd = 0;
    tag = "R6";
    irq_status = 32'h0000_0500;
    tick();
    tag = "R7";
    irq_status = 32'h0000_0504; vec_rd = 1;
    tick();
    vec_rd = 0;
    tick();

    // R9: read with nothing eligible
    tag = "R9";
    irq_status = 0; vec_rd = 1;
    tick();
    vec_rd = 0;
    tick();

    // R8: unwind
    tag = "R8";
    vec_ack = 1;
    tick();
    vec_ack = 0;
    tick();
    vec_ack = 1;
    tick();
    tick();
    vec_ack = 0;
    tick();

    // R10: read and acknowledge together
    tag = "R10";
    irq_status = 32'h0000_0040; vec_rd = 1;
    tick();
    irq_status = 32'h0000_0042; vec_rd = 1; vec_ack = 1;
    tick();
    idle_inputs();
    tick();
    tick();

    // R6: random traffic against the model
    tag = "R6";
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = int'($urandom % 4);
      irq_status  = (sel == 0) ? 32'd0 :
                    (sel == 3) ? ((32'd1 << ($urandom % 32)) | (32'd1 << ($urandom % 32)))
                               : (32'd1 << ($urandom % 32));
      nonvect_req = ($urandom % 5) == 0;
      chain_req_n = ($urandom % 6) != 0;
      chain_addr  = $urandom;
      vec_rd      = ($urandom % 4) == 0;
      vec_ack     = ($urandom % 6) == 0;
      cfg_we      = ($urandom % 40) == 0;
      cfg_slot    = 4'($urandom);
      cfg_ctrl    = 6'($urandom);
      cfg_addr    = $urandom;
      dflt_we     = ($urandom % 60) == 0;
      dflt_wdata  = $urandom;
      tick();
    end
    idle_inputs();
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule